// File: doc/BRIEF.md
# Indirect Register Port with Interrupt

This block is the host-facing slave side of a peripheral's register file. The host sees only two locations, chosen by a single address input. One location is a pointer register. The host loads it with the index of the register it wants to reach. The other location is a data window. Reads and writes through it go to whichever register the pointer currently selects. Every access is qualified by an active-low chip select. A direction input says whether the block should drive the bus or take data from it. An active-low data strobe frames each transfer. A write is committed at the moment the strobe returns high.

Register 0 holds five event flags and an interrupt enable bit. The flags record a missed packet, a memory error, a receive event, a transmit event and a primitive event. Each flag is set by a one-cycle pulse on an event input. The host clears a flag by writing a one to its bit. While the enable bit is set and at least one flag is raised, the block asks an open-drain pad to pull the active-low interrupt line to ground. The remaining registers are plain storage words. Their meaning belongs to the logic around this block.

All inputs are sampled on the system clock. The strobe's rising edge is found by comparing it with its value one clock earlier.

Top module: `irq_regport`

## Requirements
- R1: After reset the pointer is 0, every register reads 0, all flags and the enable bit are clear, the bus is not driven and the interrupt pull is off.
- R2: A write with `adr`=1 loads the pointer from the low `PTR_W` bits of `wdata`. A read with `adr`=1 returns the pointer, zero-extended.
- R3: A write with `adr`=0 goes to the register the pointer selects. A read with `adr`=0 returns that register. The pointer keeps its value through any number of data-window accesses until it is written again.
- R4: `rdata_oe` is 1 only while `cs_n`=0, `rd`=1 and `das_n`=0. With `rd`=0 the bus is never driven, and the write takes effect on the first clock edge at which `das_n` is seen high after being low.
- R5: While `cs_n`=1, strobes change no register and the bus is not driven.
- R6: Flags sit at register 0 bit 11+i, with event input `evt_set[i]` for i = 0 primitive, 1 transmit, 2 receive, 3 memory error, 4 missed packet. A pulse sets its flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set and a clear hit the same flag in the same cycle, the flag stays set.
- R7: Register 0 bit 9 is the interrupt enable. It is written and read back through the data window. Writes to register 0 leave the flags untouched wherever the written bit is 0.
- R8: `irq_pull` is 1 exactly when the enable bit is 1 and at least one flag is set. Each of the five flags alone is enough to raise it.
- R9: With the pointer at `NUM_REGS` or above, data-window writes are ignored and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adr | input | 1 | 1 = pointer location, 0 = data window |
| rd | input | 1 | 1 = block drives data, 0 = block takes data |
| das_n | input | 1 | Data strobe, active low; a write commits on its rise |
| wdata | input | DATA_W | Write data from host |
| evt_set | input | 5 | One-cycle flag set pulses |
| rdata | output | DATA_W | Read data to host |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The pointer is written with several values, and data is written through the window at more than one index. This shows that data lands where the pointer says and that the pointer survives window traffic. Flag patterns are driven one at a time, in groups, and with a set and a clear on the same edge. These patterns separate a correct write-one-to-clear from plain overwriting and check that a set wins over a clear in the same cycle. Strobes with chip select high and windows at out-of-range indexes confirm that those accesses leave the pointer and registers unchanged. The interrupt is checked with the enable off, with it on, and with each flag alone.

// File: rtl/irq_regport.sv
module irq_regport #(
  parameter int DATA_W   = 16,
  parameter int PTR_W    = 3,
  parameter int NUM_REGS = 4,
  parameter int FLAG_LSB = 11,
  parameter int IEN_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              adr,
  input  logic              rd,
  input  logic              das_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [4:0]        evt_set,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              irq_pull
);
  localparam int NFLAG = 5;

  logic             das_q;
  logic [PTR_W-1:0] ptr_q;
  logic             ien_q;
  logic [NFLAG-1:0] flags_q;
  logic [DATA_W-1:0] gp_q [NUM_REGS];

  logic wr_fire, wr_ptr, wr_data, wr_csr0;
  logic [NFLAG-1:0] clr_mask;

  assign wr_fire  = das_n & ~das_q & ~cs_n & ~rd;
  assign wr_ptr   = wr_fire & adr;
  assign wr_data  = wr_fire & ~adr;
  assign wr_csr0  = wr_data & (ptr_q == '0);
  assign clr_mask = wr_csr0 ? wdata[FLAG_LSB +: NFLAG] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) das_q <= 1'b1;
    else        das_q <= das_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ptr_q <= '0;
    else if (wr_ptr) ptr_q <= wdata[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      if (wr_csr0) ien_q <= wdata[IEN_BIT];
      flags_q <= (flags_q & ~clr_mask) | evt_set;
    end

  assign gp_q[0] = '0;
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                     gp_q[g] <= '0;
      else if (wr_data && ptr_q == PTR_W'(g))         gp_q[g] <= wdata;
  end

  logic [DATA_W-1:0] csr0_view;
  always_comb begin
    csr0_view = '0;
    csr0_view[IEN_BIT] = ien_q;
    csr0_view[FLAG_LSB +: NFLAG] = flags_q;
  end

  always_comb begin
    rdata = '0;
    if (adr) rdata[PTR_W-1:0] = ptr_q;
    else if (ptr_q == '0) rdata = csr0_view;
    else
      for (int i = 1; i < NUM_REGS; i++)
        if (ptr_q == PTR_W'(i)) rdata = gp_q[i];
  end

  assign rdata_oe = ~cs_n & rd & ~das_n;
  assign irq_pull = ien_q & |flags_q;
endmodule

module irq_regport_chk #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              adr,
  input logic              rd,
  input logic [DATA_W-1:0] wdata,
  input logic [4:0]        evt_set,
  input logic              wr_fire,
  input logic [PTR_W-1:0]  ptr_q,
  input logic              ien_q,
  input logic [4:0]        flags_q,
  input logic              rdata_oe,
  input logic              irq_pull
);
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && adr) |=> ptr_q == $past(wdata[PTR_W-1:0]));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && adr) |=> $stable(ptr_q));
  // R4
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> rd);
  // R5
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!rdata_oe && !wr_fire));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 5'd0) |=> (flags_q & $past(evt_set)) == $past(evt_set));
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 5'd0 && ien_q && !wr_fire) |=> irq_pull);
endmodule

bind irq_regport irq_regport_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adr(adr), .rd(rd), .wdata(wdata),
  .evt_set(evt_set), .wr_fire(wr_fire), .ptr_q(ptr_q), .ien_q(ien_q),
  .flags_q(flags_q), .rdata_oe(rdata_oe), .irq_pull(irq_pull)
);

// File: tb/irq_regport_tb.sv
module irq_regport_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, adr = 1'b0, rd = 1'b0, das_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [4:0]  evt_set = '0;
  logic [15:0] rdata;
  logic rdata_oe, irq_pull;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_regport dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adr(adr), .rd(rd),
    .das_n(das_n), .wdata(wdata), .evt_set(evt_set), .rdata(rdata),
    .rdata_oe(rdata_oe), .irq_pull(irq_pull));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [15:0] d);
    @(negedge clk); cs_n = 0; adr = a; rd = 0; wdata = d; das_n = 0;
    @(negedge clk); das_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic bus_rd(logic a, output logic [15:0] d, output logic oe);
    @(negedge clk); cs_n = 0; adr = a; rd = 1; das_n = 0;
    @(negedge clk); d = rdata; oe = rdata_oe; das_n = 1;
    @(negedge clk); cs_n = 1; rd = 0;
  endtask

  task automatic pulse(logic [4:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = '0;
  endtask

  logic [15:0] v; logic oe;

  task automatic t_reset;
    chk("R1 oe", {15'd0, rdata_oe}, 16'd0);
    chk("R1 irq", {15'd0, irq_pull}, 16'd0);
    bus_rd(1, v, oe); chk("R1 ptr", v, 16'd0);
    bus_rd(0, v, oe); chk("R1 csr0", v, 16'd0);
    bus_wr(1, 16'd1); bus_rd(0, v, oe); chk("R1 reg1", v, 16'd0);
  endtask

  task automatic t_pointer;
    bus_wr(1, 16'hFFF2); bus_rd(1, v, oe); chk("R2 ptr readback", v, 16'd2);
    bus_wr(0, 16'hBEEF); bus_rd(0, v, oe); chk("R3 reg2", v, 16'hBEEF);
    bus_rd(0, v, oe); chk("R3 reg2 again", v, 16'hBEEF);
    bus_rd(1, v, oe); chk("R3 ptr held", v, 16'd2);
    bus_wr(1, 16'd3); bus_wr(0, 16'h1234);
    bus_rd(0, v, oe); chk("R3 reg3", v, 16'h1234);
    bus_wr(1, 16'd2); bus_rd(0, v, oe); chk("R3 reg2 kept", v, 16'hBEEF);
  endtask

  task automatic t_dir;
    @(negedge clk); cs_n = 0; adr = 0; rd = 0; das_n = 0; wdata = 16'h5A5A;
    @(negedge clk); chk("R4 no drive on write", {15'd0, rdata_oe}, 16'd0);
    das_n = 1; @(negedge clk); cs_n = 1;
    bus_rd(0, v, oe);
    chk("R4 drive on read", {15'd0, oe}, 16'd1);
    chk("R4 write on strobe rise", v, 16'h5A5A);
  endtask

  task automatic t_cs;
    @(negedge clk); cs_n = 1; adr = 1; rd = 0; wdata = 16'd5; das_n = 0;
    @(negedge clk); das_n = 1;
    @(negedge clk); adr = 0; rd = 1; das_n = 0;
    @(negedge clk); chk("R5 no drive", {15'd0, rdata_oe}, 16'd0); das_n = 1; rd = 0;
    bus_rd(1, v, oe); chk("R5 ptr unchanged", v, 16'd2);
  endtask

  task automatic t_flags;
    bus_wr(1, 16'd0);
    pulse(5'b10101);
    bus_rd(0, v, oe); chk("R6 set", v, 16'hA800);
    bus_wr(0, 16'h8000); bus_rd(0, v, oe); chk("R6 w1c", v, 16'h2800);
    bus_wr(0, 16'h0000); bus_rd(0, v, oe); chk("R6 write zero", v, 16'h2800);
    @(negedge clk); cs_n = 0; adr = 0; rd = 0; wdata = 16'h2000; das_n = 0;
    @(negedge clk); das_n = 1; evt_set = 5'b00100;
    @(negedge clk); evt_set = '0; cs_n = 1;
    bus_rd(0, v, oe); chk("R6 set wins", v, 16'h2800);
    bus_wr(0, 16'hF800); bus_rd(0, v, oe); chk("R6 clear all", v, 16'h0000);
  endtask

  task automatic t_enable;
    pulse(5'b00010);
    chk("R8 disabled", {15'd0, irq_pull}, 16'd0);
    bus_wr(0, 16'h0200); bus_rd(0, v, oe); chk("R7 enable readback", v, 16'h1200);
    chk("R8 enabled", {15'd0, irq_pull}, 16'd1);
    bus_wr(0, 16'h1200); chk("R8 cleared", {15'd0, irq_pull}, 16'd0);
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      chk($sformatf("R8 flag %0d", i), {15'd0, irq_pull}, 16'd1);
      bus_wr(0, 16'h0200 | (16'h0800 << i));
      chk("R8 off again", {15'd0, irq_pull}, 16'd0);
    end
    bus_wr(0, 16'h0000); bus_rd(0, v, oe); chk("R7 enable off", v, 16'h0000);
  endtask

  task automatic t_range;
    bus_wr(1, 16'd5); bus_wr(0, 16'hCAFE);
    bus_rd(0, v, oe); chk("R9 out of range", v, 16'd0);
    bus_wr(1, 16'd1); bus_rd(0, v, oe); chk("R9 reg1 untouched", v, 16'd0);
    bus_wr(1, 16'd3); bus_rd(0, v, oe); chk("R9 reg3 untouched", v, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_pointer; t_dir; t_cs; t_flags; t_enable; t_range;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule